// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Forwarding Unit

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). It looks at the register fields, valid bits, write enables and load flag held in the pipeline registers behind the decode, execute, memory and write-back stages. From these it drives two bypass multiplexer selects, one per ALU operand. It also drives a stall that freezes the program counter and the fetch/decode register, and a bubble request that clears the decode/execute register.

The unit is fully combinational. The operand selects depend only on what the downstream pipeline registers hold in the current cycle. Nothing decided at decode time is carried forward, so an instruction that stalls and later resumes gets selects that match the pipeline state at the moment it executes. Two situations stall the instruction in decode. The first is a load in execute whose destination the decode instruction reads, because the load data is not available until the memory stage has finished. The second is a decode instruction that needs both register-file ports in the same cycle that write-back uses the shared read/write port.

Top module: `hz_unit`

## Requirements
- R1: Each operand select uses this encoding: 2'b00 means the register-file value, 2'b01 means the write-back stage result (MEM/WB register), and 2'b10 means the memory stage result (EX/MEM register). The value 2'b11 is never produced.
- R2: An operand of a valid execute-stage instruction selects 2'b10 when the operand is read, the memory-stage entry is valid with its write enable set, and its destination equals the operand's source field.
- R3: When R2 does not apply, an operand selects 2'b01 if the write-back entry is valid, has its write enable set, and has a destination equal to the source field. Otherwise it selects 2'b00.
- R4: When both the memory-stage and the write-back entries match the same source, the memory-stage result (2'b10) wins.
- R5: Register 0 is never forwarded, and a load with destination 0 never stalls.
- R6: An operand whose use bit is 0 selects 2'b00 and causes no load-use stall, whatever its source field holds.
- R7: A valid load in execute, with write enable set and a nonzero destination equal to a source read by a valid decode instruction, raises stall and bubble together.
- R8: A valid decode instruction that reads both operands raises stall and bubble while the write-back entry is valid, has its write enable set and has a nonzero destination.
- R9: An entry whose valid bit is 0 takes part in no forwarding and no stall. With an invalid execute entry both selects are 2'b00, and with an invalid decode entry there is no stall.
- R10: When there is no load-use or port conflict, stall and bubble are 0, and bubble always equals stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode-stage instruction is valid |
| id_rs1 | input | REG_AW | Decode first source register |
| id_rs2 | input | REG_AW | Decode second source register |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_valid | input | 1 | Execute-stage entry (ID/EX) is valid |
| ex_rs1 | input | REG_AW | Execute first source register |
| ex_rs2 | input | REG_AW | Execute second source register |
| ex_use_rs1 | input | 1 | Execute instruction reads operand A |
| ex_use_rs2 | input | 1 | Execute instruction reads operand B |
| ex_rd | input | REG_AW | Execute destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | EX/MEM entry is valid |
| mem_rd | input | REG_AW | EX/MEM destination register |
| mem_wen | input | 1 | EX/MEM entry writes a register |
| wb_valid | input | 1 | MEM/WB entry is valid |
| wb_rd | input | REG_AW | MEM/WB destination register |
| wb_wen | input | 1 | MEM/WB entry writes a register |
| fwd_a_sel | output | 2 | Operand A bypass select |
| fwd_b_sel | output | 2 | Operand B bypass select |
| stall | output | 1 | Hold PC and the IF/ID register |
| bubble | output | 1 | Clear valid and write enable of the incoming ID/EX entry |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle as the input pattern that exposes it. A wrong priority or a missing qualifier gives a wrong select code, a spurious stall or a missing stall. These are seen directly, with no delay to wait out. Random patterns over a narrow register range make source and destination matches common, and directed cases target priority, register 0, unused operands, invalid entries and the two stall causes.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
    import hz_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              cons_valid,
    input  logic              use_src,
    input  logic [REG_AW-1:0] src,
    input  logic              mem_valid,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              wb_valid,
    input  logic              wb_wen,
    input  logic [REG_AW-1:0] wb_rd,
    output logic [1:0]        sel
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    typedef struct packed {
        logic     hit_mem;
        logic     hit_wb;
        fwd_sel_e sel;
    } fwd_res_t;

    fwd_res_t res_d;

    always_comb begin
        res_d         = '0;
        res_d.hit_mem = cons_valid && use_src && (src != ZERO_REG)
                        && mem_valid && mem_wen && (mem_rd == src);
        res_d.hit_wb  = cons_valid && use_src && (src != ZERO_REG)
                        && wb_valid && wb_wen && (wb_rd == src);
        if (res_d.hit_mem)
            res_d.sel = SEL_MEM;
        else if (res_d.hit_wb)
            res_d.sel = SEL_WB;
        else
            res_d.sel = SEL_RF;
    end

    assign sel = res_d.sel;

    always_comb begin
        AST_SEL_LEGAL: assert (sel != 2'b11) else $error("illegal select");      // R1
        AST_ZERO_NOFWD: assert (src != ZERO_REG || sel == 2'b00) else $error("r0 forwarded"); // R5
        AST_UNUSED_RF: assert (use_src || sel == 2'b00) else $error("unused operand forwarded"); // R6
        AST_NOCONS_RF: assert (cons_valid || sel == 2'b00) else $error("invalid consumer forwarded"); // R9
    end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
    parameter int unsigned REG_AW = 5
) (
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_use_rs1,
    input  logic              id_use_rs2,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic              load_use,
    output logic              port_conflict
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    typedef struct packed {
        logic load_pending;
        logic wb_port_busy;
        logic load_use;
        logic port_conflict;
    } ilk_res_t;

    ilk_res_t res_d;

    always_comb begin
        res_d               = '0;
        res_d.load_pending  = ex_valid && ex_is_load && ex_wen && (ex_rd != ZERO_REG);
        res_d.wb_port_busy  = wb_valid && wb_wen && (wb_rd != ZERO_REG);
        res_d.load_use      = id_valid && res_d.load_pending
                              && ((id_use_rs1 && id_rs1 == ex_rd)
                               || (id_use_rs2 && id_rs2 == ex_rd));
        res_d.port_conflict = id_valid && id_use_rs1 && id_use_rs2 && res_d.wb_port_busy;
    end

    assign load_use      = res_d.load_use;
    assign port_conflict = res_d.port_conflict;

    always_comb begin
        AST_LOAD_R0_NOSTALL: assert (ex_rd != ZERO_REG || !load_use) else $error("r0 load stall"); // R5
        AST_LOAD_NEEDS_READ: assert (id_use_rs1 || id_use_rs2 || !load_use) else $error("stall without read"); // R6
        AST_PORT_NEEDS_WB: assert (!port_conflict || (wb_valid && wb_wen)) else $error("port conflict without write"); // R8
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              id_valid,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_use_rs1,
    input  logic              id_use_rs2,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic              ex_use_rs1,
    input  logic              ex_use_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic              mem_valid,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              wb_valid,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_wen,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              stall,
    output logic              bubble
);
    logic [REG_AW-1:0] opnd_src [NUM_OPND];
    logic              opnd_use [NUM_OPND];
    logic [1:0]        opnd_sel [NUM_OPND];

    assign opnd_src[0] = ex_rs1;
    assign opnd_src[1] = ex_rs2;
    assign opnd_use[0] = ex_use_rs1;
    assign opnd_use[1] = ex_use_rs2;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        hz_fwd_select #(.REG_AW(REG_AW)) u_sel (
            .cons_valid (ex_valid),
            .use_src    (opnd_use[g]),
            .src        (opnd_src[g]),
            .mem_valid  (mem_valid),
            .mem_wen    (mem_wen),
            .mem_rd     (mem_rd),
            .wb_valid   (wb_valid),
            .wb_wen     (wb_wen),
            .wb_rd      (wb_rd),
            .sel        (opnd_sel[g])
        );
    end

    logic load_use;
    logic port_conflict;

    hz_interlock #(.REG_AW(REG_AW)) u_ilk (
        .id_valid      (id_valid),
        .id_rs1        (id_rs1),
        .id_rs2        (id_rs2),
        .id_use_rs1    (id_use_rs1),
        .id_use_rs2    (id_use_rs2),
        .ex_valid      (ex_valid),
        .ex_rd         (ex_rd),
        .ex_wen        (ex_wen),
        .ex_is_load    (ex_is_load),
        .wb_valid      (wb_valid),
        .wb_rd         (wb_rd),
        .wb_wen        (wb_wen),
        .load_use      (load_use),
        .port_conflict (port_conflict)
    );

    typedef struct packed {
        logic [1:0] fwd_a;
        logic [1:0] fwd_b;
        logic       hold;
        logic       flush;
    } ctl_t;

    ctl_t ctl_d;

    always_comb begin
        ctl_d       = '0;
        ctl_d.fwd_a = opnd_sel[0];
        ctl_d.fwd_b = opnd_sel[1];
        ctl_d.hold  = load_use || port_conflict;
        ctl_d.flush = ctl_d.hold;
    end

    assign fwd_a_sel = ctl_d.fwd_a;
    assign fwd_b_sel = ctl_d.fwd_b;
    assign stall     = ctl_d.hold;
    assign bubble    = ctl_d.flush;

    always_comb begin
        AST_STALL_NEEDS_ID: assert (id_valid || !stall) else $error("stall with empty decode"); // R9
        AST_STALL_HAS_CAUSE: assert (!stall || (ex_valid && ex_is_load) || wb_valid) else $error("stall without cause"); // R10
    end
endmodule

// File: tb/hz_unit_tb.sv
`timescale 1ns/1ps
module hz_unit_tb;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          id_valid, id_use_rs1, id_use_rs2;
    logic [AW-1:0] id_rs1, id_rs2;
    logic          ex_valid, ex_use_rs1, ex_use_rs2, ex_wen, ex_is_load;
    logic [AW-1:0] ex_rs1, ex_rs2, ex_rd;
    logic          mem_valid, mem_wen, wb_valid, wb_wen;
    logic [AW-1:0] mem_rd, wb_rd;
    logic [1:0]    fwd_a_sel, fwd_b_sel;
    logic          stall, bubble;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    hz_unit #(.REG_AW(AW)) u_dut (.*);

    function automatic logic [1:0] ref_sel(logic [AW-1:0] s, logic u);
        if (!ex_valid || !u || s == 0) return 2'b00;
        if (mem_valid && mem_wen && mem_rd == s) return 2'b10;
        if (wb_valid && wb_wen && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic ref_stall();
        logic lu, pc;
        lu = id_valid && ex_valid && ex_is_load && ex_wen && ex_rd != 0 &&
             ((id_use_rs1 && id_rs1 == ex_rd) || (id_use_rs2 && id_rs2 == ex_rd));
        pc = id_valid && id_use_rs1 && id_use_rs2 && wb_valid && wb_wen && wb_rd != 0;
        return lu || pc;
    endfunction

    task automatic idle();
        {id_valid, id_use_rs1, id_use_rs2} = '0; id_rs1 = '0; id_rs2 = '0;
        {ex_valid, ex_use_rs1, ex_use_rs2, ex_wen, ex_is_load} = '0;
        ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
        {mem_valid, mem_wen, wb_valid, wb_wen} = '0; mem_rd = '0; wb_rd = '0;
    endtask

    task automatic chk(string tag);
        logic [1:0] ea, eb;
        logic es;
        #1;
        ea = ref_sel(ex_rs1, ex_use_rs1);
        eb = ref_sel(ex_rs2, ex_use_rs2);
        es = ref_stall();
        checks++;
        if (fwd_a_sel !== ea || fwd_b_sel !== eb || stall !== es || bubble !== es) begin
            failures++;
            $display("FAIL %s: a=%b b=%b stall=%b bubble=%b expected a=%b b=%b stall=%b bubble=%b",
                     tag, fwd_a_sel, fwd_b_sel, stall, bubble, ea, eb, es, es);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        @(negedge clk); chk("R10 idle");

        // R2: EX/MEM match on operand A
        @(negedge clk); idle(); ex_valid = 1; ex_use_rs1 = 1; ex_rs1 = 5;
        mem_valid = 1; mem_wen = 1; mem_rd = 5; chk("R2");
        // R3: MEM/WB match on operand B
        @(negedge clk); idle(); ex_valid = 1; ex_use_rs2 = 1; ex_rs2 = 7;
        wb_valid = 1; wb_wen = 1; wb_rd = 7; chk("R3");
        // R4: both match, MEM wins
        @(negedge clk); idle(); ex_valid = 1; ex_use_rs1 = 1; ex_use_rs2 = 1; ex_rs1 = 3; ex_rs2 = 3;
        mem_valid = 1; mem_wen = 1; mem_rd = 3; wb_valid = 1; wb_wen = 1; wb_rd = 3; chk("R4");
        // R1: mixed encodings on both operands
        @(negedge clk); idle(); ex_valid = 1; ex_use_rs1 = 1; ex_use_rs2 = 1; ex_rs1 = 9; ex_rs2 = 4;
        mem_valid = 1; mem_wen = 1; mem_rd = 4; wb_valid = 1; wb_wen = 1; wb_rd = 9; chk("R1");
        // R5: register 0 not forwarded, load to r0 no stall
        @(negedge clk); idle(); ex_valid = 1; ex_use_rs1 = 1; ex_rs1 = 0;
        mem_valid = 1; mem_wen = 1; mem_rd = 0; chk("R5 fwd");
        @(negedge clk); idle(); id_valid = 1; id_use_rs1 = 1; id_rs1 = 0;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 0; chk("R5 load");
        // R6: unused operands
        @(negedge clk); idle(); ex_valid = 1; ex_rs1 = 6; mem_valid = 1; mem_wen = 1; mem_rd = 6; chk("R6 fwd");
        @(negedge clk); idle(); id_valid = 1; id_rs2 = 8; id_use_rs1 = 1; id_rs1 = 2;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 8; chk("R6 stall");
        // R7: load-use on each source
        @(negedge clk); idle(); id_valid = 1; id_use_rs1 = 1; id_rs1 = 11;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 11; chk("R7 rs1");
        @(negedge clk); idle(); id_valid = 1; id_use_rs2 = 1; id_rs2 = 12;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 12; chk("R7 rs2");
        // R8: port conflict
        @(negedge clk); idle(); id_valid = 1; id_use_rs1 = 1; id_use_rs2 = 1; id_rs1 = 1; id_rs2 = 2;
        wb_valid = 1; wb_wen = 1; wb_rd = 20; chk("R8");
        @(negedge clk); idle(); id_valid = 1; id_use_rs1 = 1; id_rs1 = 1;
        wb_valid = 1; wb_wen = 1; wb_rd = 20; chk("R8 single read");
        // R9: invalid entries ignored
        @(negedge clk); idle(); ex_use_rs1 = 1; ex_rs1 = 5; mem_valid = 1; mem_wen = 1; mem_rd = 5; chk("R9 ex");
        @(negedge clk); idle(); ex_valid = 1; ex_use_rs1 = 1; ex_rs1 = 5; mem_wen = 1; mem_rd = 5; chk("R9 mem");
        @(negedge clk); idle(); id_use_rs1 = 1; id_rs1 = 11; ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 11; chk("R9 id");
        // R10: non-load producer in EX does not stall
        @(negedge clk); idle(); id_valid = 1; id_use_rs1 = 1; id_rs1 = 11; ex_valid = 1; ex_wen = 1; ex_rd = 11; chk("R10");

        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            {id_valid, id_use_rs1, id_use_rs2} = 3'($urandom);
            id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
            {ex_valid, ex_use_rs1, ex_use_rs2, ex_wen, ex_is_load} = 5'($urandom);
            ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
            ex_rd = AW'($urandom_range(0, 3));
            {mem_valid, mem_wen, wb_valid, wb_wen} = 4'($urandom);
            mem_rd = AW'($urandom_range(0, 3)); wb_rd = AW'($urandom_range(0, 3));
            chk("R1 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule